// File: doc/BRIEF.md
# Masked Reduction Flag Unit

This unit sits beside an ALU and turns a whole 64-bit operand into one condition bit. A bit-mask picks the operand bits that take part. Those bits are then collapsed through one wide gate (AND, OR, NAND, NOR or XOR). The unit can also compare two masked words for equal, greater-than or less-than. The unit writes no data word. Its only result is the flag.

An operation is issued with a one-cycle `issue` strobe. The flag appears three clock edges later, and `flag_valid` marks that one cycle as the slot for the next instruction. If the next instruction raises `consume` in that slot, the flag keeps its value. If it does not, the flag clears to 0. While an operation is in flight, `busy` is high and further issues are dropped.

Top module: `masked_reduce_flag`

## Requirements
- R1: Opcode 0 (AND) gives 1 when every bit enabled by `mask` is 1 in `opnd_a`. Bits with a mask bit of 0 act as 1, so an all-zero mask gives 1.
- R2: Opcode 1 (OR) gives 1 when any enabled bit of `opnd_a` is 1. Opcode 3 (NOR) gives its inverse. With an all-zero mask, OR gives 0 and NOR gives 1.
- R3: Opcode 2 (NAND) gives the inverse of the opcode 0 result, so an all-zero mask gives 0.
- R4: Opcode 4 (XOR) gives the parity of the enabled bits of `opnd_a`. An all-zero mask gives 0.
- R5: Opcodes 5 (equal), 6 (greater-than) and 7 (less-than) compare `opnd_a & mask` with `opnd_b & mask` as unsigned values. The flag is 1 only when the relation holds, and bits whose mask bit is 0 never change the outcome.
- R6: Take an issue accepted at clock edge k. `busy` is high in the three cycles after edges k, k+1 and k+2. `flag_valid` and the new flag appear after edge k+3, and at that point `busy` is low.
- R7: An `issue` seen while `busy` is high is ignored. It produces no further `flag_valid` pulse and does not alter the pending result.
- R8: `flag_valid` is high for exactly one cycle per accepted operation.
- R9: If `consume` is high in the `flag_valid` cycle, `flag` keeps its value afterwards. If it is low, `flag` is 0 from the next cycle.
- R10: A synchronous active-high `rst` clears `busy`, `flag_valid` and `flag`, and drops any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Start an operation this cycle |
| op | input | 3 | Operation code (0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR, 5 EQ, 6 GT, 7 LT) |
| opnd_a | input | W | Operand reduced or compared |
| opnd_b | input | W | Second compare operand |
| mask | input | W | Enabled bit positions |
| consume | input | 1 | Next instruction uses the flag |
| busy | output | 1 | Operation in flight |
| flag | output | 1 | Condition result |
| flag_valid | output | 1 | Slot in which the flag may be consumed |

## Verification
A wrong stage counter shows up at once as a `busy` window that is not three cycles long, or as a missing or doubled `flag_valid` pulse, within four cycles of the issue. A corrupted lane partial or a wrong lane-priority compare gives a wrong `flag` in the valid slot itself. The slot-end clear or hold becomes visible one cycle later. A busy guard that leaks lets an ignored issue surface as a second valid pulse within two cycles of the first.

// File: rtl/masked_reduce_flag.sv
module masked_reduce_flag #(
  parameter int W    = 64,
  parameter int LANE = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] mask,
  input  logic         consume,
  output logic         busy,
  output logic         flag,
  output logic         flag_valid
);
  localparam int NL = W / LANE;
  localparam logic [2:0] OP_AND = 3'd0, OP_OR = 3'd1, OP_NAND = 3'd2, OP_NOR = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4, OP_EQ = 3'd5, OP_GT = 3'd6, OP_LT = 3'd7;

  logic [1:0]    stage;
  logic [2:0]    op1, op2;
  logic [W-1:0]  a1, b1, m1;
  logic [NL-1:0] l_and, l_or, l_xor, l_eq, l_gt, l_lt;
  logic [NL-1:0] r_and, r_or, r_xor, r_eq, r_gt, r_lt;
  logic          cmp_gt, cmp_lt, res_c, res3;

  assign busy = stage != 2'd0;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LANE-1:0] sa, sb, sm;
    assign sa = a1[g*LANE +: LANE];
    assign sb = b1[g*LANE +: LANE];
    assign sm = m1[g*LANE +: LANE];
    assign l_and[g] = &(sa | ~sm);
    assign l_or[g]  = |sa;
    assign l_xor[g] = ^sa;
    assign l_eq[g]  = sa == sb;
    assign l_gt[g]  = sa > sb;
    assign l_lt[g]  = sa < sb;
  end

  always_comb begin
    cmp_gt = 1'b0;
    cmp_lt = 1'b0;
    for (int i = 0; i < NL; i++)
      if (!r_eq[i]) begin
        cmp_gt = r_gt[i];
        cmp_lt = r_lt[i];
      end
    case (op2)
      OP_AND:  res_c = &r_and;
      OP_OR:   res_c = |r_or;
      OP_NAND: res_c = ~&r_and;
      OP_NOR:  res_c = ~|r_or;
      OP_XOR:  res_c = ^r_xor;
      OP_EQ:   res_c = &r_eq;
      OP_GT:   res_c = cmp_gt;
      OP_LT:   res_c = cmp_lt;
      default: res_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (issue && !busy) begin
      a1  <= opnd_a & mask;
      b1  <= opnd_b & mask;
      m1  <= mask;
      op1 <= op;
    end
    if (stage == 2'd1) begin
      r_and <= l_and; r_or <= l_or; r_xor <= l_xor;
      r_eq  <= l_eq;  r_gt <= l_gt; r_lt  <= l_lt;
      op2   <= op1;
    end
    if (stage == 2'd2) res3 <= res_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage      <= 2'd0;
      flag       <= 1'b0;
      flag_valid <= 1'b0;
    end else begin
      flag_valid <= 1'b0;
      if (flag_valid && !consume) flag <= 1'b0;
      case (stage)
        2'd0: if (issue) stage <= 2'd1;
        2'd1: stage <= 2'd2;
        2'd2: stage <= 2'd3;
        default: begin
          stage      <= 2'd0;
          flag       <= res3;
          flag_valid <= 1'b1;
        end
      endcase
    end
  end

  // R6
  busy_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 busy ##1 (!busy && flag_valid));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flag_valid |=> !flag_valid);
  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_valid && !consume) |=> !flag);
  // R9
  keep_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_valid && consume) |=> flag == $past(flag));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !flag_valid && !flag));
  // R7
  no_valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !flag_valid);
endmodule

// File: tb/masked_reduce_flag_tb.sv
module masked_reduce_flag_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] a = '0, b = '0, m = '0;
  logic        consume = 1'b0;
  logic        busy, flag, flag_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  masked_reduce_flag #(.W(64), .LANE(8)) dut_i (
    .clk(clk), .rst(rst), .issue(issue), .op(op), .opnd_a(a), .opnd_b(b),
    .mask(m), .consume(consume), .busy(busy), .flag(flag), .flag_valid(flag_valid));

  function automatic logic ref_flag(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic [63:0] k);
    case (o)
      3'd0: return &(x | ~k);
      3'd1: return |(x & k);
      3'd2: return ~&(x | ~k);
      3'd3: return ~|(x & k);
      3'd4: return ^(x & k);
      3'd5: return (x & k) == (y & k);
      3'd6: return (x & k) > (y & k);
      default: return (x & k) < (y & k);
    endcase
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R1 AND";
      3'd1: return "R2 OR";
      3'd2: return "R3 NAND";
      3'd3: return "R2 NOR";
      3'd4: return "R4 XOR";
      default: return "R5 compare";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [2:0] o, logic [63:0] x, logic [63:0] y, logic [63:0] k,
                        bit cons, bit stray);
    logic e;
    e = ref_flag(o, x, y, k);
    @(negedge clk); issue = 1'b1; op = o; a = x; b = y; m = k;
    @(negedge clk); issue = 1'b0;
    check("R6 busy after issue", busy, 1);
    check("R6 no early valid", flag_valid, 0);
    if (stray) begin issue = 1'b1; op = ~o; a = ~x; b = ~y; m = ~k; end
    @(negedge clk); issue = 1'b0;
    check("R6 busy mid", busy, 1);
    @(negedge clk);
    check("R6 busy last", busy, 1);
    @(negedge clk);
    check("R6 valid at latency", flag_valid, 1);
    check("R6 busy low at valid", busy, 0);
    check(req_of(o), flag, e);
    consume = cons;
    @(negedge clk); consume = 1'b0;
    check("R8 single valid", flag_valid, 0);
    check("R9 flag after slot", flag, cons ? e : 1'b0);
    if (stray) begin
      @(negedge clk);
      check("R7 stray ignored", flag_valid, 0);
    end
  endtask

  initial begin
    logic [63:0] x, y, k;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check("R10 reset busy", busy, 0);
    check("R10 reset valid", flag_valid, 0);
    check("R10 reset flag", flag, 0);
    rst = 1'b0;

    for (int o = 0; o < 8; o++) run_op(3'(o), 64'hFFFF_0000_1234_5678, 64'h1, 64'h0, 1'b1, 1'b0);
    run_op(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run_op(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run_op(3'd0, 64'h00F0, 0, 64'h00F0, 1'b1, 1'b0);
    run_op(3'd1, 64'h8000_0000_0000_0000, 0, 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    run_op(3'd4, 64'h0000_0000_0000_0007, 0, 64'h0000_0000_0000_0003, 1'b1, 1'b0);
    run_op(3'd6, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run_op(3'd7, 64'h0100, 64'h00FF, 64'hFFFF, 1'b1, 1'b0);
    run_op(3'd5, 64'h8000_0000_0000_0000, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run_op(3'd6, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0002, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    run_op(3'd3, 64'h1, 0, 64'h1, 1'b1, 1'b1);
    run_op(3'd5, 64'h55, 64'h55, 64'hFF, 1'b0, 1'b1);

    @(negedge clk); issue = 1'b1; op = 3'd0; a = '1; m = '1;
    @(negedge clk); issue = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 mid reset busy", busy, 0);
    check("R10 mid reset flag", flag, 0);
    repeat (3) begin
      @(negedge clk);
      check("R10 dropped op", flag_valid, 0);
    end

    for (int n = 0; n < 400; n++) begin
      x = {$urandom, $urandom};
      case ($urandom % 4)
        0: k = '1;
        1: k = '0;
        2: k = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        default: k = {$urandom, $urandom};
      endcase
      if ($urandom % 4 == 0) x = x | ~k;
      y = ($urandom % 2) ? (x ^ ({$urandom, $urandom} & ~k)) : {$urandom, $urandom};
      run_op(3'($urandom % 8), x, y, k, 1'($urandom % 2), ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule